// File: doc/BRIEF.md
# Native Burst Request Front-End

This block is a plain user port, without any bus protocol, in front of a burst memory controller. A user first stages write words, each with a per-byte mask, in a write buffer. The user then pulses a start input for one cycle with a direction bit, a burst length and a 32-bit address. The block checks the two mode bits at the top of the address. If they are accepted, it runs the burst against a back-end, which is modelled here by a small byte-lane storage responder. While the burst runs, an idle output is low. Read bursts return one word per cycle with a valid strobe.

The number of user words in a burst is the burst length times RATIO. RATIO is twice the memory data width divided by the user word width, and it is 1 with the defaults (8-bit memory, 16-bit words). The write buffer is sized to RATIO times the largest burst. Write bursts drain the buffer in the order it was filled, and the words land at consecutive word addresses. The word address is taken from the low address bits and wraps at the top of the storage.

Top module: `nb_top`

## Requirements
- R1: After a synchronous reset, idle is 1, wr_ready is 1 and rd_valid is 0.
- R2: A word and its mask are stored when wr_en is high and wr_ready is high. wr_ready is low exactly when the buffer holds BUF_DEPTH words (32 by default), and a word offered while it is low is dropped.
- R3: A start is accepted only when addr[31] is 1, addr[30] is 0 and the length is non-zero. Any other start leaves idle high and produces no read data.
- R4: A write start (dir = 0) is ignored unless the buffer already holds at least RATIO × length words.
- R5: After an accepted start, idle is low from the next cycle on, for RATIO × length + 1 cycles, and then returns high.
- R6: A write burst stores the buffered words, oldest first, at word addresses addr[7:0], addr[7:0]+1, and so on. The address wraps from 255 to 0.
- R7: Mask bit i set to 1 keeps byte i (bits 8i+7:8i) of the stored word unchanged. An all-zero mask writes the whole word.
- R8: A read burst (dir = 1) returns exactly RATIO × length words in ascending address order, one per rd_valid pulse. The first valid comes two clock edges after the start was sampled, and rd_valid is never high while idle is high.
- R9: A start that arrives while idle is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request pulse |
| dir | input | 1 | 0 = write burst, 1 = read burst |
| len | input | 12 | Burst length in memory units |
| addr | input | 32 | Bit 31 = linear mode (must be 1), bit 30 = space (must be 0), low bits = word address |
| wr_en | input | 1 | Push a word into the write buffer |
| wr_data | input | 16 | Word to buffer |
| wr_mask | input | 2 | Per-byte keep mask (1 = leave byte unchanged) |
| rd_data | output | 16 | Read word |
| rd_valid | output | 1 | rd_data is valid this cycle |
| idle | output | 1 | No burst in progress |
| wr_ready | output | 1 | Write buffer can take a word |

## Verification
The assertions take the user to send start as a single-cycle pulse, and to change the buffer and the request inputs only at times the requirements allow. For this reason, the acceptance checks look only at the inputs sampled together with start. The bench drives every input on the falling edge, holds start for exactly one rising edge, and pushes only whole bursts or the deliberate partial fills needed for the refused-start and overflow cases. Reads cover only locations the bench has written, so every expected word comes from its own model of the storage.

// File: rtl/nb_pkg.sv
package nb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } nb_state_t;
endpackage

// File: rtl/nb_wbuf.sv
module nb_wbuf #(
  parameter int DW    = 16,
  parameter int MW    = 2,
  parameter int DEPTH = 32,
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic [MW-1:0] min,
  input  logic          pop,
  output logic [DW-1:0] head_d,
  output logic [MW-1:0] head_m,
  output logic [FW-1:0] fill,
  output logic          ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW+MW-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok;

  assign ready   = (fill != FW'(DEPTH));
  assign push_ok = push && ready;
  assign {head_m, head_d} = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= {min, din};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)     rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/nb_seq.sv
module nb_seq
  import nb_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int MEM_AW = 8,
  parameter int RATIO  = 1,
  parameter int FW     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir,
  input  logic [LEN_W-1:0]  len,
  input  logic [31:0]       addr,
  input  logic [FW-1:0]     fill,
  output logic              pop,
  output logic              mem_we,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              idle
);
  localparam int CW = LEN_W + $clog2(RATIO) + 1;

  nb_state_t         state;
  logic              dir_q;
  logic [CW-1:0]     remain;
  logic [MEM_AW-1:0] ptr;
  logic [CW-1:0]     need;
  logic              mode_ok, room_ok, accept, busy;
  logic              unused_addr_bits;

  assign unused_addr_bits = ^addr[29:MEM_AW];
  assign need     = CW'(len) * CW'(RATIO);
  assign mode_ok  = addr[31] && !addr[30];
  assign room_ok  = dir || (CW'(fill) >= need);
  assign accept   = (state == ST_IDLE) && start && mode_ok && (len != '0) && room_ok;
  assign busy     = (state == ST_XFER);
  assign mem_we   = busy && !dir_q;
  assign mem_re   = busy && dir_q;
  assign pop      = mem_we;
  assign mem_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      idle   <= 1'b1;
      dir_q  <= 1'b0;
      remain <= '0;
      ptr    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_XFER;
          idle   <= 1'b0;
          dir_q  <= dir;
          remain <= need;
          ptr    <= addr[MEM_AW-1:0];
        end
        ST_XFER: begin
          ptr    <= ptr + 1'b1;
          remain <= remain - 1'b1;
          if (remain == CW'(1)) state <= ST_FIN;
        end
        ST_FIN: begin
          state <= ST_IDLE;
          idle  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nb_mem.sv
module nb_mem #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  input  logic [DW/8-1:0] keep,
  output logic [DW-1:0] rd,
  output logic          rvalid
);
  localparam int LANES = DW / 8;
  localparam int WORDS = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane [WORDS];
    always_ff @(posedge clk) begin
      if (we && !keep[g]) lane[addr] <= wd[g*8 +: 8];
      if (re) rd[g*8 +: 8] <= lane[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end
endmodule

// File: rtl/nb_top.sv
module nb_top #(
  parameter int DW      = 16,
  parameter int DQ_W    = 8,
  parameter int LEN_W   = 12,
  parameter int MAX_LEN = 32,
  parameter int MEM_AW  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             dir,
  input  logic [LEN_W-1:0] len,
  input  logic [31:0]      addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW/8-1:0]  wr_mask,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             idle,
  output logic             wr_ready
);
  localparam int MW        = DW / 8;
  localparam int RATIO     = (DQ_W * 2) / DW;
  localparam int BUF_DEPTH = RATIO * MAX_LEN;
  localparam int FW        = $clog2(BUF_DEPTH + 1);

  logic [FW-1:0]     fill;
  logic [DW-1:0]     head_d;
  logic [MW-1:0]     head_m;
  logic              pop, mem_we, mem_re;
  logic [MEM_AW-1:0] mem_addr;

  nb_wbuf #(.DW(DW), .MW(MW), .DEPTH(BUF_DEPTH), .FW(FW)) u_wbuf (
    .clk(clk), .rst(rst), .push(wr_en), .din(wr_data), .min(wr_mask),
    .pop(pop), .head_d(head_d), .head_m(head_m), .fill(fill), .ready(wr_ready)
  );

  nb_seq #(.LEN_W(LEN_W), .MEM_AW(MEM_AW), .RATIO(RATIO), .FW(FW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .dir(dir), .len(len), .addr(addr),
    .fill(fill), .pop(pop), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .idle(idle)
  );

  nb_mem #(.DW(DW), .AW(MEM_AW)) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .re(mem_re), .addr(mem_addr),
    .wd(head_d), .keep(head_m), .rd(rd_data), .rvalid(rd_valid)
  );
endmodule

// File: rtl/nb_chk.sv
module nb_chk #(
  parameter int LEN_W = 12,
  parameter int FW    = 6,
  parameter int DEPTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             dir,
  input logic [LEN_W-1:0] len,
  input logic [31:0]      addr,
  input logic             idle,
  input logic             rd_valid,
  input logic             wr_ready,
  input logic [FW-1:0]    fill
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) fill <= FW'(DEPTH)); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst) (!wr_ready && idle) |=> !wr_ready); // R2
  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (idle && start && (!addr[31] || addr[30])) |=> idle); // R3
  AST_ZERO_LEN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (idle && start && len == '0) |=> idle); // R3
  AST_IDLE_DROP: assert property (@(posedge clk) disable iff (rst)
    (idle && start && dir && addr[31] && !addr[30] && len != '0) |=> !idle); // R5
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (rst) rd_valid |-> !idle); // R8
endmodule

bind nb_top nb_chk #(.LEN_W(LEN_W), .FW(FW), .DEPTH(BUF_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .dir(dir), .len(len), .addr(addr),
  .idle(idle), .rd_valid(rd_valid), .wr_ready(wr_ready), .fill(fill)
);

// File: tb/sim_nb_top.sv
module sim_nb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int MW = 2;
  localparam int DEPTH = 32;
  // fields: addr[29:22], len[21:16], seed[15:0]
  localparam logic [29:0] VEC [5] = '{
    {8'h00, 6'd1,  16'h1234},
    {8'h10, 6'd4,  16'hA000},
    {8'hFC, 6'd8,  16'h0F0F},
    {8'h20, 6'd16, 16'h5A00},
    {8'h30, 6'd3,  16'hFFFF}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, dir = 1'b0, wr_en = 1'b0;
  logic [11:0] len = '0;
  logic [31:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [MW-1:0] wr_mask = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, idle, wr_ready;

  int total = 0, bad = 0, cycles = 0;
  logic [15:0] exp_mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  nb_top u0 (.clk(clk), .rst(rst), .start(start), .dir(dir), .len(len), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask), .rd_data(rd_data),
    .rd_valid(rd_valid), .idle(idle), .wr_ready(wr_ready));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [15:0] d, input logic [1:0] m);
    wr_en = 1'b1; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fire(input logic d, input int n, input logic [31:0] a);
    start = 1'b1; dir = d; len = 12'(n); addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [15:0] word_of(input logic [15:0] seed, input int i);
    return seed + 16'(i) * 16'h0101;
  endfunction

  // R5 R6 R7: push words skip..n-1, launch write, time idle, update model
  task automatic do_write(input logic [7:0] a, input int n, input logic [15:0] seed,
                          input logic [1:0] m, input int skip);
    int lows;
    for (int i = skip; i < n; i++) push(word_of(seed, i), m);
    fire(1'b0, n, {2'b10, 22'd0, a});
    lows = 0;
    while (!idle && lows < 2000) begin
      lows++;
      @(negedge clk);
    end
    chk(lows == n + 1, "R5 write idle-low cycles", lows, n + 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] wa;
      logic [15:0] w;
      wa = a + 8'(i);
      w = word_of(seed, i);
      if (!m[0]) exp_mem[wa][7:0] = w[7:0];
      if (!m[1]) exp_mem[wa][15:8] = w[15:8];
    end
  endtask

  // R8: read back and compare in address order
  task automatic do_read(input logic [7:0] a, input int n, input string req);
    int idx, s, first;
    idx = 0; s = 1; first = -1;
    fire(1'b1, n, {2'b10, 22'd0, a});
    chk(idle == 1'b0, {req, " R5 idle low after read start"}, idle, 0);
    while (s < 2000) begin
      if (rd_valid) begin
        chk(rd_data == exp_mem[a + 8'(idx)], {req, " R8 read word"}, rd_data, exp_mem[a + 8'(idx)]);
        if (first < 0) first = s;
        idx++;
      end
      if (idle) break;
      @(negedge clk);
      s++;
    end
    chk(idx == n, {req, " R8 word count"}, idx, n);
    chk(first == 2, {req, " R8 first valid timing"}, first, 2);
  endtask

  task automatic quiet(input int n, input string req);
    int v;
    v = 0;
    for (int i = 0; i < n; i++) begin
      if (rd_valid || !idle) v++;
      @(negedge clk);
    end
    chk(v == 0, req, v, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(idle == 1'b1, "R1 idle after reset", idle, 1);
    chk(wr_ready == 1'b1, "R1 wr_ready after reset", wr_ready, 1);
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);

    // table walk: write then read back (R6 order, wrap at 0xFC)
    for (int k = 0; k < 5; k++) begin
      do_write(VEC[k][29:22], int'(VEC[k][21:16]), VEC[k][15:0], 2'b00, 0);
      do_read(VEC[k][29:22], int'(VEC[k][21:16]), "R6 table");
    end

    // R3 reserved mode bits and zero length
    fire(1'b1, 4, 32'h0000_0010);
    chk(idle == 1'b1, "R3 bit31 clear ignored", idle, 1);
    quiet(6, "R3 no activity bit31 clear");
    fire(1'b1, 4, 32'hC000_0010);
    chk(idle == 1'b1, "R3 bit30 set ignored", idle, 1);
    quiet(6, "R3 no activity bit30 set");
    fire(1'b1, 0, 32'h8000_0010);
    chk(idle == 1'b1, "R3 zero length ignored", idle, 1);
    quiet(6, "R3 no activity zero length");

    // R4 write with short buffer
    push(word_of(16'h7700, 0), 2'b00);
    push(word_of(16'h7700, 1), 2'b00);
    fire(1'b0, 4, 32'h8000_0060);
    chk(idle == 1'b1, "R4 short buffer start ignored", idle, 1);
    quiet(4, "R4 no activity short buffer");
    do_write(8'h60, 4, 16'h7700, 2'b00, 2);
    do_read(8'h60, 4, "R4 after refill");

    // R9 start while busy
    for (int i = 0; i < 4; i++) push(word_of(16'h4400, i), 2'b00);
    begin
      int v, w;
      v = 0; w = 0;
      fire(1'b0, 4, 32'h8000_0040);
      fire(1'b1, 4, 32'h8000_0010);
      while (!idle && w < 100) begin
        if (rd_valid) v++;
        w++;
        @(negedge clk);
      end
      for (int i = 0; i < 4; i++) exp_mem[8'h40 + 8'(i)] = word_of(16'h4400, i);
      chk(w == 4, "R9 write ran undisturbed", w, 4);
      quiet(8, "R9 busy start dropped");
      chk(v == 0, "R9 no read data during busy", v, 0);
    end
    do_read(8'h40, 4, "R9 data intact");

    // R7 byte mask
    do_write(8'h50, 1, 16'hAAAA, 2'b00, 0);
    do_write(8'h51, 1, 16'hAAAA, 2'b00, 0);
    do_write(8'h50, 1, 16'h5555, 2'b10, 0);
    do_write(8'h51, 1, 16'h5555, 2'b01, 0);
    do_read(8'h50, 2, "R7 mask");

    // R2 full buffer, dropped extra word
    for (int i = 0; i < DEPTH; i++) push(word_of(16'h3100, i), 2'b00);
    chk(wr_ready == 1'b0, "R2 ready low when full", wr_ready, 0);
    push(16'hDEAD, 2'b00);
    chk(wr_ready == 1'b0, "R2 ready stays low", wr_ready, 0);
    do_write(8'h80, DEPTH, 16'h3100, 2'b00, DEPTH);
    chk(wr_ready == 1'b1, "R2 ready high after drain", wr_ready, 1);
    do_read(8'h80, DEPTH, "R2 full burst");
    do_write(8'hC0, 1, 16'h2468, 2'b00, 0);
    do_read(8'hC0, 1, "R2 extra word dropped");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule